// File: doc/BRIEF.md
# Multi-Plane Bitmap Memory Port

This block gives a host processor word and byte access to a bitmap store made of three 16-bit memory planes. A base register places the access window in the host byte address space; an access falls in the window when the address bits above the window size equal that register. A three-bit plane-enable mask chooses what each access reaches. A write goes to every enabled plane in the same cycle. A read returns a single plane, chosen by fixed priority from the lowest enabled plane number.

Every write that lands in the window also reports the line of words it touched on a dirty-line output, so that a display cache can drop that line. The report is made even when no plane is enabled. The block keeps a scroll register and presents the row offset derived from it to the display fetch logic.

After reset, a sweep clears all plane memory, and the host is held off with a ready signal until the sweep is complete. The plane memories are synchronous RAMs, so read data returns one cycle after the read is accepted.

Top module: `bitplane_port`

## Requirements
- R1: An access is in the window when host_addr[HADDR_W-1:WIN_SHIFT] equals the base register, which is loaded through base_we/base_wdata. The plane word index is host_addr[PLANE_AW:1], so higher bits inside the window alias onto the same word.
- R2: A read in the window with a non-zero mask returns plane 0 if mask bit 0 is set. Otherwise it returns plane 1 if bit 1 is set, and otherwise plane 2. Mask bit i stands for plane i.
- R3: A read in the window with mask 3'b000 returns NOREG_VAL, which is 16'hFFFF by default.
- R4: A write in the window updates, in its accept cycle, every plane whose mask bit is set, and leaves the other planes unchanged.
- R5: host_be[0] enables data bits 7:0 and host_be[1] enables bits 15:8. A byte lane whose enable is low keeps its old value.
- R6: scroll_val holds the last value loaded through scroll_we. row_offset equals {scroll_val[7:0], 6'b0}, which is the scroll value shifted left by 6 and kept to bits 13:6.
- R7: Reset sets scroll_val to 16'hFF00 (row_offset 0) and sets the base register and mask to zero. The reset input is synchronised with two flops. After reset is released, host_ready stays low for 2 + 2**PLANE_AW cycles while every plane word is cleared to zero.
- R8: Every write accepted in the window, including one made with mask 3'b000, raises dirty_valid for exactly the following cycle. In that cycle dirty_line equals the word index shifted right by LINE_LOG2.
- R9: An access outside the window raises host_miss for the cycle after it is accepted. Such a write changes no plane and raises no dirty_valid. Such a read returns 0.
- R10: A request is accepted when host_req and host_ready are both high. host_rvalid is high exactly in the cycle after an accepted read, and host_rdata is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | HADDR_W | Host byte address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte lane enables |
| host_ready | output | 1 | Block can accept a request |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 16 | Read data |
| host_miss | output | 1 | Previous access fell outside the window |
| dirty_valid | output | 1 | A word was written in the window |
| dirty_line | output | PLANE_AW-LINE_LOG2 | Line index of the written word |
| base_we | input | 1 | Load base register |
| base_wdata | input | HADDR_W-WIN_SHIFT | New window base |
| mask_we | input | 1 | Load plane-enable mask |
| mask_wdata | input | 3 | New plane-enable mask |
| scroll_we | input | 1 | Load scroll register |
| scroll_wdata | input | 16 | New scroll value |
| scroll_val | output | 16 | Current scroll register |
| row_offset | output | 14 | Row offset for display fetch |

## Verification
The bench builds the block with PLANE_AW=6, which gives 64 words per plane, and with LINE_LOG2=2. The clearing sweep therefore ends after 66 cycles, and its exact length can be checked on host_ready. The small depth also lets every word index used by the bench land on a distinct, predictable dirty line. Keeping the default window of 2**15 bytes with 22 address bits leaves seven base bits, so the bench can move the window to base 5 and hit both in-window and out-of-window addresses.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int NUM_PLANES = 3;

  typedef enum logic [1:0] {
    PSEL_0    = 2'd0,
    PSEL_1    = 2'd1,
    PSEL_2    = 2'd2,
    PSEL_NONE = 2'd3
  } plane_sel_e;
endpackage

// File: rtl/bp_window_decode.sv
module bp_window_decode #(
  parameter int HADDR_W   = 22,
  parameter int WIN_SHIFT = 15,
  parameter int PLANE_AW  = 8,
  localparam int BASE_W   = HADDR_W - WIN_SHIFT
) (
  input  logic [HADDR_W-1:0]  addr_i,
  input  logic [BASE_W-1:0]   base_i,
  output logic                hit_o,
  output logic [PLANE_AW-1:0] word_idx_o
);
  assign hit_o      = (addr_i[HADDR_W-1:WIN_SHIFT] == base_i);
  assign word_idx_o = addr_i[PLANE_AW:1];
endmodule

// File: rtl/bp_plane_ram.sv
module bp_plane_ram #(
  parameter int DW = 16,
  parameter int AW = 8,
  localparam int LANES = DW / 8,
  localparam int DEPTH = 2 ** AW
) (
  input  logic             clk,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [LANES-1:0] be_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (be_i[l]) mem[addr_i][l*8 +: 8] <= wdata_i[l*8 +: 8];
      end
    end
    if (rd_en_i) rdata_q <= mem[addr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/bp_clear_seq.sv
module bp_clear_seq #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          busy_o,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == {AW{1'b1}}) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;
  assign addr_o = cnt_q;
endmodule

// File: rtl/bitplane_port.sv
module bitplane_port
  import bp_pkg::*;
#(
  parameter int          HADDR_W   = 22,
  parameter int          WIN_SHIFT = 15,
  parameter int          PLANE_AW  = 8,
  parameter int          LINE_LOG2 = 2,
  parameter logic [15:0] NOREG_VAL = 16'hFFFF,
  localparam int DW      = 16,
  localparam int BE_W    = DW / 8,
  localparam int BASE_W  = HADDR_W - WIN_SHIFT,
  localparam int LINE_IW = PLANE_AW - LINE_LOG2,
  localparam int ROW_SH  = 6,
  localparam int ROW_W   = 14,
  localparam int NP      = NUM_PLANES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [DW-1:0]      host_wdata,
  input  logic [BE_W-1:0]    host_be,
  output logic               host_ready,
  output logic               host_rvalid,
  output logic [DW-1:0]      host_rdata,
  output logic               host_miss,
  output logic               dirty_valid,
  output logic [LINE_IW-1:0] dirty_line,
  input  logic               base_we,
  input  logic [BASE_W-1:0]  base_wdata,
  input  logic               mask_we,
  input  logic [NP-1:0]      mask_wdata,
  input  logic               scroll_we,
  input  logic [DW-1:0]      scroll_wdata,
  output logic [DW-1:0]      scroll_val,
  output logic [ROW_W-1:0]   row_offset
);
  // reset synchroniser
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // clearing sweep
  logic                clr_busy;
  logic [PLANE_AW-1:0] clr_addr;

  bp_clear_seq #(.AW(PLANE_AW)) u_clear (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .busy_o (clr_busy),
    .addr_o (clr_addr)
  );

  // window decode
  logic [BASE_W-1:0]   base_q, base_d;
  logic                hit;
  logic [PLANE_AW-1:0] word_idx;

  bp_window_decode #(
    .HADDR_W  (HADDR_W),
    .WIN_SHIFT(WIN_SHIFT),
    .PLANE_AW (PLANE_AW)
  ) u_decode (
    .addr_i     (host_addr),
    .base_i     (base_q),
    .hit_o      (hit),
    .word_idx_o (word_idx)
  );

  logic [NP-1:0]      mask_q, mask_d;
  logic [DW-1:0]      scroll_q, scroll_d;
  logic               acc, acc_rd, acc_wr;
  plane_sel_e         sel_q, sel_d;
  logic               rd_pend_q, rd_pend_d;
  logic               miss_q, miss_d;
  logic               dirty_q, dirty_d;
  logic [LINE_IW-1:0] line_q, line_d;

  assign acc    = host_req & host_ready;
  assign acc_rd = acc & ~host_we;
  assign acc_wr = acc & host_we;

  // planes
  logic [DW-1:0] plane_rd [NP];

  for (genvar p = 0; p < NP; p++) begin : g_plane
    logic                wr_en;
    logic [BE_W-1:0]     be;
    logic [PLANE_AW-1:0] addr;
    logic [DW-1:0]       wdata;

    assign wr_en = clr_busy | (acc_wr & hit & mask_q[p]);
    assign be    = clr_busy ? {BE_W{1'b1}} : host_be;
    assign addr  = clr_busy ? clr_addr : word_idx;
    assign wdata = clr_busy ? '0 : host_wdata;

    bp_plane_ram #(.DW(DW), .AW(PLANE_AW)) u_ram (
      .clk     (clk),
      .wr_en_i (wr_en),
      .rd_en_i (acc_rd),
      .be_i    (be),
      .addr_i  (addr),
      .wdata_i (wdata),
      .rdata_o (plane_rd[p])
    );
  end

  // next state
  always_comb begin
    base_d    = base_we   ? base_wdata   : base_q;
    mask_d    = mask_we   ? mask_wdata   : mask_q;
    scroll_d  = scroll_we ? scroll_wdata : scroll_q;
    rd_pend_d = acc_rd;
    miss_d    = acc & ~hit;
    dirty_d   = acc_wr & hit;
    line_d    = word_idx[PLANE_AW-1:LINE_LOG2];
    sel_d     = PSEL_NONE;
    for (int i = NP - 1; i >= 0; i--) begin
      if (mask_q[i]) sel_d = plane_sel_e'(2'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      base_q    <= '0;
      mask_q    <= '0;
      scroll_q  <= 16'hFF00;
      rd_pend_q <= 1'b0;
      miss_q    <= 1'b0;
      dirty_q   <= 1'b0;
      line_q    <= '0;
      sel_q     <= PSEL_NONE;
    end else begin
      base_q    <= base_d;
      mask_q    <= mask_d;
      scroll_q  <= scroll_d;
      rd_pend_q <= rd_pend_d;
      miss_q    <= miss_d;
      dirty_q   <= dirty_d;
      if (dirty_d) line_q <= line_d;
      if (acc_rd)  sel_q  <= sel_d;
    end
  end

  // outputs
  always_comb begin
    host_rdata = '0;
    if (rd_pend_q && !miss_q) begin
      case (sel_q)
        PSEL_0:  host_rdata = plane_rd[0];
        PSEL_1:  host_rdata = plane_rd[1];
        PSEL_2:  host_rdata = plane_rd[2];
        default: host_rdata = NOREG_VAL;
      endcase
    end
  end

  assign host_ready  = ~clr_busy;
  assign host_rvalid = rd_pend_q;
  assign host_miss   = miss_q;
  assign dirty_valid = dirty_q;
  assign dirty_line  = line_q;
  assign scroll_val  = scroll_q;
  assign row_offset  = {scroll_q[ROW_W-ROW_SH-1:0], {ROW_SH{1'b0}}};
endmodule

// File: rtl/bp_port_chk.sv
module bp_port_chk #(
  parameter int          HADDR_W   = 22,
  parameter int          WIN_SHIFT = 15,
  parameter logic [15:0] NOREG_VAL = 16'hFFFF,
  localparam int BASE_W = HADDR_W - WIN_SHIFT
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_req,
  input logic               host_we,
  input logic [HADDR_W-1:0] host_addr,
  input logic               host_ready,
  input logic               host_rvalid,
  input logic [15:0]        host_rdata,
  input logic               host_miss,
  input logic               dirty_valid,
  input logic [BASE_W-1:0]  base_q,
  input logic [2:0]         mask_q,
  input logic               scroll_we,
  input logic [15:0]        scroll_wdata,
  input logic [13:0]        row_offset
);
  logic in_win;
  assign in_win = (host_addr[HADDR_W-1:WIN_SHIFT] == base_q);

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && host_ready && !host_we |=> host_rvalid); // R10
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && host_ready && !host_we) |=> !host_rvalid); // R10
  AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid && host_miss |-> host_rdata == 16'h0); // R9
  AST_MISS_NO_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    host_miss |-> !dirty_valid); // R9
  AST_EMPTY_MASK_NOREG: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && host_ready && !host_we && in_win && mask_q == 3'b000
    |=> host_rdata == NOREG_VAL); // R3
  AST_WRITE_MARKS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && host_ready && host_we && in_win |=> dirty_valid); // R8
  AST_SCROLL_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    scroll_we |=> row_offset[13:6] == $past(scroll_wdata[7:0])); // R6
endmodule

bind bitplane_port bp_port_chk #(
  .HADDR_W  (HADDR_W),
  .WIN_SHIFT(WIN_SHIFT),
  .NOREG_VAL(NOREG_VAL)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .host_req     (host_req),
  .host_we      (host_we),
  .host_addr    (host_addr),
  .host_ready   (host_ready),
  .host_rvalid  (host_rvalid),
  .host_rdata   (host_rdata),
  .host_miss    (host_miss),
  .dirty_valid  (dirty_valid),
  .base_q       (base_q),
  .mask_q       (mask_q),
  .scroll_we    (scroll_we),
  .scroll_wdata (scroll_wdata),
  .row_offset   (row_offset)
);

// File: tb/bitplane_port_tb.sv
module bitplane_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HADDR_W    = 22;
  localparam int WIN_SHIFT  = 15;
  localparam int PLANE_AW   = 6;
  localparam int LINE_LOG2  = 2;
  localparam int DEPTH      = 2 ** PLANE_AW;
  localparam int BASE_W     = HADDR_W - WIN_SHIFT;
  localparam int LINE_IW    = PLANE_AW - LINE_LOG2;
  localparam int NOREG      = 16'hFFFF;

  logic clk = 1'b0;
  logic rst_n;
  logic host_req, host_we;
  logic [HADDR_W-1:0] host_addr;
  logic [15:0] host_wdata;
  logic [1:0]  host_be;
  logic host_ready, host_rvalid, host_miss, dirty_valid;
  logic [15:0] host_rdata;
  logic [LINE_IW-1:0] dirty_line;
  logic base_we, mask_we, scroll_we;
  logic [BASE_W-1:0] base_wdata;
  logic [2:0]  mask_wdata;
  logic [15:0] scroll_wdata, scroll_val;
  logic [13:0] row_offset;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitplane_port #(
    .HADDR_W(HADDR_W), .WIN_SHIFT(WIN_SHIFT), .PLANE_AW(PLANE_AW),
    .LINE_LOG2(LINE_LOG2), .NOREG_VAL(16'hFFFF)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_be(host_be),
    .host_ready(host_ready), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .host_miss(host_miss), .dirty_valid(dirty_valid), .dirty_line(dirty_line),
    .base_we(base_we), .base_wdata(base_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .scroll_we(scroll_we), .scroll_wdata(scroll_wdata),
    .scroll_val(scroll_val), .row_offset(row_offset)
  );

  // reference model state
  int pmem [3][DEPTH];
  int m_base, m_mask, m_scroll, clr_left;
  int e_rvalid, e_rdata, e_miss, e_dv, e_line, e_ready;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string tag = "R7";

  task automatic chk(input string t, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int acc, hit, idx, rd;
    acc = host_req && (clr_left == 0);
    if (clr_left > 0) clr_left--;
    e_rvalid = 0; e_miss = 0; e_dv = 0;
    if (acc) begin
      hit = ((int'(host_addr) >> WIN_SHIFT) == m_base);
      idx = (int'(host_addr) >> 1) & (DEPTH - 1);
      if (!hit) e_miss = 1;
      if (host_we) begin
        if (hit) begin
          for (int p = 0; p < 3; p++) begin
            if (m_mask[p]) begin
              if (host_be[0]) pmem[p][idx] = (pmem[p][idx] & 'hFF00) | (host_wdata & 'h00FF);
              if (host_be[1]) pmem[p][idx] = (pmem[p][idx] & 'h00FF) | (host_wdata & 'hFF00);
            end
          end
          e_dv = 1;
          e_line = idx >> LINE_LOG2;
        end
      end else begin
        e_rvalid = 1;
        if (!hit)                 rd = 0;
        else if (m_mask == 0)     rd = NOREG;
        else if (m_mask[0])       rd = pmem[0][idx];
        else if (m_mask[1])       rd = pmem[1][idx];
        else                      rd = pmem[2][idx];
        e_rdata = rd;
      end
    end
    if (base_we)   m_base   = base_wdata;
    if (mask_we)   m_mask   = mask_wdata;
    if (scroll_we) m_scroll = scroll_wdata;
    e_ready = (clr_left == 0);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, "host_ready", host_ready, e_ready);
    chk(tag, "host_rvalid", host_rvalid, e_rvalid);
    chk(tag, "host_miss", host_miss, e_miss);
    chk(tag, "dirty_valid", dirty_valid, e_dv);
    if (e_rvalid) chk(tag, "host_rdata", host_rdata, e_rdata);
    if (e_dv)     chk(tag, "dirty_line", dirty_line, e_line);
    chk(tag, "scroll_val", scroll_val, m_scroll);
    chk(tag, "row_offset", row_offset, (m_scroll & 'hFF) << 6);
    host_req = 0; host_we = 0; base_we = 0; mask_we = 0; scroll_we = 0;
  endtask

  task automatic acc_op(input string t, input bit we, input int addr, input int data, input int be);
    tag = t; host_req = 1; host_we = we; host_addr = addr[HADDR_W-1:0];
    host_wdata = data[15:0]; host_be = be[1:0];
    step();
  endtask

  function automatic int wa(input int base, input int idx);
    return (base << WIN_SHIFT) | (idx << 1);
  endfunction

  task automatic set_mask(input int m);
    tag = "R2"; mask_we = 1; mask_wdata = m[2:0]; step();
  endtask

  initial begin
    rst_n = 0; host_req = 0; host_we = 0; host_addr = '0; host_wdata = '0;
    host_be = 2'b11; base_we = 0; base_wdata = '0; mask_we = 0; mask_wdata = '0;
    scroll_we = 0; scroll_wdata = '0;
    m_base = 0; m_mask = 0; m_scroll = 'hFF00;
    for (int p = 0; p < 3; p++) for (int i = 0; i < DEPTH; i++) pmem[p][i] = 0;
    repeat (3) @(negedge clk);
    // R7: values held during reset
    chk("R7", "host_ready in reset", host_ready, 0);
    chk("R7", "scroll_val in reset", scroll_val, 'hFF00);
    chk("R7", "row_offset in reset", row_offset, 0);
    rst_n = 1;
    clr_left = DEPTH + 2;
    tag = "R7";
    while (clr_left > 0) step();
    // R7: cleared memory, reads zero through every plane
    set_mask(7);
    acc_op("R7", 0, wa(0, 9), 0, 3);
    set_mask(2);
    acc_op("R7", 0, wa(0, 9), 0, 3);
    set_mask(4);
    acc_op("R7", 0, wa(0, 9), 0, 3);
    // R3: empty mask
    set_mask(0);
    acc_op("R3", 0, wa(0, 2), 0, 3);
    // R4: broadcast write, R8 dirty line
    set_mask(7);
    acc_op("R4", 1, wa(0, 13), 'h1234, 3);
    acc_op("R2", 0, wa(0, 13), 0, 3);
    set_mask(2);
    acc_op("R4", 1, wa(0, 13), 'hAAAA, 3);
    acc_op("R2", 0, wa(0, 13), 0, 3);
    set_mask(6);
    acc_op("R2", 0, wa(0, 13), 0, 3);
    set_mask(4);
    acc_op("R4", 0, wa(0, 13), 0, 3);
    set_mask(3);
    acc_op("R2", 0, wa(0, 13), 0, 3);
    // R5: byte lanes
    set_mask(1);
    acc_op("R5", 1, wa(0, 13), 'hFFEE, 1);
    acc_op("R5", 0, wa(0, 13), 0, 3);
    acc_op("R5", 1, wa(0, 13), 'h7799, 2);
    acc_op("R5", 0, wa(0, 13), 0, 3);
    // R8: write with empty mask still marks dirty, changes nothing
    set_mask(0);
    acc_op("R8", 1, wa(0, 40), 'hBEEF, 3);
    set_mask(7);
    acc_op("R8", 0, wa(0, 40), 0, 3);
    // R1: aliasing of upper in-window bits
    acc_op("R1", 0, (1 << 10) | wa(0, 13), 0, 3);
    // R1/R9: move window
    tag = "R1"; base_we = 1; base_wdata = 7'd5; step();
    acc_op("R9", 0, wa(0, 13), 0, 3);
    acc_op("R9", 1, wa(0, 13), 'h0F0F, 3);
    acc_op("R1", 0, wa(5, 13), 0, 3);
    acc_op("R1", 1, wa(5, 63), 'hC3C3, 3);
    acc_op("R10", 0, wa(5, 63), 0, 3);
    acc_op("R10", 0, wa(5, 13), 0, 3);
    acc_op("R9", 0, wa(6, 63), 0, 3);
    tag = "R10"; step();
    // R6: scroll
    tag = "R6"; scroll_we = 1; scroll_wdata = 16'h1234; step();
    tag = "R6"; scroll_we = 1; scroll_wdata = 16'h00FF; step();
    tag = "R6"; step();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule